// File: doc/BRIEF.md
# Polar Code Belief Propagation Decoder

This block decodes one length-8 polar codeword at a time by iterative message passing over the three-boundary butterfly graph of the code. Each graph node holds a left-going and a right-going soft message. These are 8-bit two's-complement log-likelihood ratios, where a positive value favours bit 0. A start pulse loads the eight channel LLRs at the codeword side of the graph. It also loads a prior at the message side, which pins the frozen positions strongly towards 0.

Each iteration has two sweeps. The first sweep runs from the message side towards the codeword side and updates the right-going messages. The second sweep comes back and updates the left-going messages. All butterflies use the min-sum rule, and every stored message is clamped to a fixed limit. One column of four butterfly units is shared by all three boundaries, so each sweep takes one cycle per boundary.

At the end of each iteration the block raises a check request for one cycle and presents hard decisions on the message bits and the codeword bits. An external checker answers in that same cycle. A pass stops the decoder. Otherwise it keeps iterating up to an iteration cap, then reports done together with the number of iterations it ran.

Top module: `polar_bp_decoder`

## Requirements
- R1: After reset, busy_o, done_o and chk_req_o are 0 and iters_o is 0.
- R2: When start_i is accepted, every node message is reloaded as follows:
  - Codeword-side left messages, node i: the signed byte llr_i[8i+7:8i], clamped to ±20.
  - Message-side right messages, node i: +20 where frozen_i[i] is 1, and 0 elsewhere.
  - All other messages: 0.
  The codeword-side left messages then stay unchanged until the next accepted start.
- R3: One iteration is a right-going sweep followed by a left-going sweep.
  - Boundary s (s = 0, 1, 2, counted from the message side) pairs nodes j and j+2^s, for every j whose bit s is 0.
  - The right-going sweep visits s = 0, 1, 2. It writes the next stage's right message at j as g(Ra, Lb+Rb) and at j+2^s as g(Ra, La)+Rb.
  - The left-going sweep visits s = 2, 1, 0. It writes this stage's left message at j as g(La, Lb+Rb) and at j+2^s as g(Ra, La)+Lb.
  - Ra and Rb are the right messages at j and j+2^s on the near side. La and Lb are the left messages at j and j+2^s on the far side.
  - g(a,b) is sign(a)·sign(b)·min(|a|,|b|).
- R4: Every stored message lies within ±20 (LIM). Each butterfly result is clamped to that range.
- R5: u_hat_o[i] is 1 exactly when the left plus right message of message-side node i is negative. x_hat_o[i] is the same test on codeword-side node i. Both are valid while chk_req_o or done_o is high.
- R6: chk_req_o rises 6 (2n) clock cycles after the edge that accepts start_i. Each following request comes 7 (2n+1) cycles after the previous one, and each lasts exactly one cycle.
- R7: check_pass_i high during a chk_req_o cycle ends decoding. done_o is then 1 in the next cycle, busy_o is 0, and iters_o equals the number of completed iterations.
- R8: Without a pass, decoding ends after the 50th iteration with done_o high and iters_o = 50. iters_o never exceeds 50.
- R9: start_i is ignored while busy_o is high, that is during the sweeps and the check cycle. Neither the frame nor its timing changes.
- R10: While done_o is high, the values of u_hat_o, x_hat_o and iters_o hold regardless of the other inputs. A start_i in that state launches a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a new frame (accepted when not busy) |
| llr_i | input | 64 | Channel LLRs, node i in bits [8i+7:8i], signed |
| frozen_i | input | 8 | Frozen-position mask, 1 = frozen |
| check_pass_i | input | 1 | External check result, sampled while chk_req_o is high |
| busy_o | output | 1 | Frame in progress |
| chk_req_o | output | 1 | End of an iteration; decisions valid for checking |
| done_o | output | 1 | Decoding finished; held until next start |
| iters_o | output | 6 | Completed iterations of the current or last frame |
| u_hat_o | output | 8 | Hard decisions on message bits |
| x_hat_o | output | 8 | Hard decisions on codeword bits |

## Verification
The bench compares the hard decisions after every single iteration with its own model, using both saturating inputs (±127, -128) and random frozen masks.

The following faults each show up in those per-iteration comparisons:
- A swapped butterfly span or a wrong sweep order.
- A missing clamp.
- A frozen prior with the wrong sign.
- A minimum taken over signed rather than absolute values.

The iteration-cap frame catches an off-by-one stop, which ends at 49 or 51. The cycle counts to each check request catch a lost or extra pipeline cycle. A start pulse with changed LLRs sent in the middle of a frame would, if wrongly accepted, reload the graph and diverge from the model. A frame left idle after done, with its inputs scrambled, catches decisions that are not held.

// File: rtl/polar_bp_pkg.sv
package polar_bp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_EVAL,
    ST_DONE
  } bp_state_e;

  function automatic int sat_lim(int v, int lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  // min-sum kernel: sign(a)*sign(b)*min(|a|,|b|)
  function automatic int g_min(int a, int b);
    int ma;
    int mb;
    int m;
    ma = (a < 0) ? -a : a;
    mb = (b < 0) ? -b : b;
    m  = (ma < mb) ? ma : mb;
    return ((a < 0) != (b < 0)) ? -m : m;
  endfunction

endpackage

// File: rtl/polar_bp_pe.sv
module polar_bp_pe #(
  parameter int W   = 8,
  parameter int LIM = 20
) (
  input  logic signed [W-1:0] r_a_i,
  input  logic signed [W-1:0] r_b_i,
  input  logic signed [W-1:0] l_a_i,
  input  logic signed [W-1:0] l_b_i,
  output logic signed [W-1:0] r_a_o,
  output logic signed [W-1:0] r_b_o,
  output logic signed [W-1:0] l_a_o,
  output logic signed [W-1:0] l_b_o
);
  import polar_bp_pkg::*;

  always_comb begin
    int ra;
    int rb;
    int la;
    int lb;
    int gx;
    ra = int'(r_a_i);
    rb = int'(r_b_i);
    la = int'(l_a_i);
    lb = int'(l_b_i);
    gx = g_min(ra, la);
    r_a_o = W'(sat_lim(g_min(ra, lb + rb), LIM));
    r_b_o = W'(sat_lim(gx + rb, LIM));
    l_a_o = W'(sat_lim(g_min(la, lb + rb), LIM));
    l_b_o = W'(sat_lim(gx + lb, LIM));
  end

endmodule

// File: rtl/polar_bp_ctrl.sv
module polar_bp_ctrl #(
  parameter int N_LOG    = 3,
  parameter int MAX_ITER = 50,
  localparam int STW = $clog2(2 * N_LOG),
  localparam int SW  = $clog2(N_LOG + 1),
  localparam int ITW = $clog2(MAX_ITER + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           check_pass_i,
  output logic           load_o,
  output logic           step_en_o,
  output logic           dir_left_o,
  output logic [SW-1:0]  bnd_o,
  output logic           chk_req_o,
  output logic           busy_o,
  output logic           done_o,
  output logic [ITW-1:0] iters_o
);
  import polar_bp_pkg::*;

  localparam logic [STW-1:0] LAST = STW'(2 * N_LOG - 1);
  localparam logic [ITW-1:0] CAP  = ITW'(MAX_ITER);

  bp_state_e      state_q;
  logic [STW-1:0] step_q;
  logic [ITW-1:0] iter_q;

  assign load_o     = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign step_en_o  = (state_q == ST_RUN);
  assign dir_left_o = (step_q >= STW'(N_LOG));
  assign bnd_o      = dir_left_o ? SW'(LAST - step_q) : SW'(step_q);
  assign chk_req_o  = (state_q == ST_EVAL);
  assign busy_o     = (state_q == ST_RUN) || (state_q == ST_EVAL);
  assign done_o     = (state_q == ST_DONE);
  assign iters_o    = iter_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      iter_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            step_q  <= '0;
            iter_q  <= '0;
          end
        end
        ST_RUN: begin
          if (step_q == LAST) begin
            step_q  <= '0;
            iter_q  <= iter_q + ITW'(1);
            state_q <= ST_EVAL;
          end else begin
            step_q <= step_q + STW'(1);
          end
        end
        ST_EVAL: begin
          if (check_pass_i || iter_q == CAP) state_q <= ST_DONE;
          else                               state_q <= ST_RUN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  iter_le_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iters_o <= CAP);

  // R7
  done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(chk_req_o) && ($past(check_pass_i) || iters_o == CAP)));

  // R6
  chk_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_req_o |=> !chk_req_o);

  // R9
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && iters_o != '0) |=> (iters_o != '0));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

endmodule

// File: rtl/polar_bp_decoder.sv
module polar_bp_decoder #(
  parameter int N_LOG    = 3,
  parameter int W        = 8,
  parameter int LIM      = 20,
  parameter int MAX_ITER = 50,
  localparam int N   = 1 << N_LOG,
  localparam int NP  = N / 2,
  localparam int STG = N_LOG + 1,
  localparam int SW  = $clog2(N_LOG + 1),
  localparam int IW  = N_LOG,
  localparam int ITW = $clog2(MAX_ITER + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N*W-1:0] llr_i,
  input  logic [N-1:0]   frozen_i,
  input  logic           check_pass_i,
  output logic           busy_o,
  output logic           chk_req_o,
  output logic           done_o,
  output logic [ITW-1:0] iters_o,
  output logic [N-1:0]   u_hat_o,
  output logic [N-1:0]   x_hat_o
);
  import polar_bp_pkg::*;

  localparam logic signed [W-1:0] LIM_W = W'(LIM);

  logic signed [W-1:0] l_q [STG][N];
  logic signed [W-1:0] r_q [STG][N];
  logic signed [W-1:0] chan_sat [N];

  logic          load;
  logic          step_en;
  logic          dir_left;
  logic [SW-1:0] bnd;
  logic [SW-1:0] bnd_up;

  logic [IW-1:0]       jt [NP];
  logic [IW-1:0]       jb [NP];
  logic signed [W-1:0] pr_a [NP];
  logic signed [W-1:0] pr_b [NP];
  logic signed [W-1:0] pl_a [NP];
  logic signed [W-1:0] pl_b [NP];
  logic signed [W-1:0] or_a [NP];
  logic signed [W-1:0] or_b [NP];
  logic signed [W-1:0] ol_a [NP];
  logic signed [W-1:0] ol_b [NP];

  polar_bp_ctrl #(
    .N_LOG   (N_LOG),
    .MAX_ITER(MAX_ITER)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .check_pass_i(check_pass_i),
    .load_o      (load),
    .step_en_o   (step_en),
    .dir_left_o  (dir_left),
    .bnd_o       (bnd),
    .chk_req_o   (chk_req_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .iters_o     (iters_o)
  );

  assign bnd_up = bnd + SW'(1);

  for (genvar i = 0; i < N; i++) begin : g_chan
    assign chan_sat[i] = W'(sat_lim(int'($signed(llr_i[i*W +: W])), LIM));
  end

  // shared PE column, butterfly span 2^bnd
  for (genvar p = 0; p < NP; p++) begin : g_pe
    assign jt[p] = IW'(((p >> bnd) << (bnd + 1)) | (p & ((1 << bnd) - 1)));
    assign jb[p] = IW'(((p >> bnd) << (bnd + 1)) | (p & ((1 << bnd) - 1)) | (1 << bnd));
    assign pr_a[p] = r_q[bnd][jt[p]];
    assign pr_b[p] = r_q[bnd][jb[p]];
    assign pl_a[p] = l_q[bnd_up][jt[p]];
    assign pl_b[p] = l_q[bnd_up][jb[p]];

    polar_bp_pe #(
      .W  (W),
      .LIM(LIM)
    ) u_pe (
      .r_a_i(pr_a[p]),
      .r_b_i(pr_b[p]),
      .l_a_i(pl_a[p]),
      .l_b_i(pl_b[p]),
      .r_a_o(or_a[p]),
      .r_b_o(or_b[p]),
      .l_a_o(ol_a[p]),
      .l_b_o(ol_b[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STG; s++) begin
        for (int i = 0; i < N; i++) begin
          l_q[s][i] <= '0;
          r_q[s][i] <= '0;
        end
      end
    end else if (load) begin
      for (int s = 0; s < STG; s++) begin
        for (int i = 0; i < N; i++) begin
          l_q[s][i] <= (s == STG - 1) ? chan_sat[i] : '0;
          r_q[s][i] <= (s == 0 && frozen_i[i]) ? LIM_W : '0;
        end
      end
    end else if (step_en) begin
      for (int p = 0; p < NP; p++) begin
        if (dir_left) begin
          l_q[bnd][jt[p]] <= ol_a[p];
          l_q[bnd][jb[p]] <= ol_b[p];
        end else begin
          r_q[bnd_up][jt[p]] <= or_a[p];
          r_q[bnd_up][jb[p]] <= or_b[p];
        end
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_dec
    logic [W:0] su;
    logic [W:0] sx;
    assign su = {l_q[0][i][W-1], l_q[0][i]} + {r_q[0][i][W-1], r_q[0][i]};
    assign sx = {l_q[STG-1][i][W-1], l_q[STG-1][i]} + {r_q[STG-1][i][W-1], r_q[STG-1][i]};
    assign u_hat_o[i] = su[W];
    assign x_hat_o[i] = sx[W];
  end

  for (genvar s = 0; s < STG; s++) begin : g_rng_s
    for (genvar i = 0; i < N; i++) begin : g_rng_i
      // R4
      msg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (l_q[s][i] <= LIM_W) && (l_q[s][i] >= -LIM_W) &&
        (r_q[s][i] <= LIM_W) && (r_q[s][i] >= -LIM_W));
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_ld_chk
    // R2
    prior_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(load && rst_ni) |-> (r_q[0][i] == ($past(frozen_i[i]) ? LIM_W : '0)));
    // R2
    chan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load |=> $stable(l_q[STG-1][i]));
  end

endmodule

// File: tb/polar_bp_decoder_tb.sv
module polar_bp_decoder_tb;

  localparam int LIMV = 20;
  localparam int CAPV = 50;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] llr_i = '0;
  logic [7:0]  frozen_i = '0;
  logic        check_pass_i = 1'b0;
  logic        busy_o;
  logic        chk_req_o;
  logic        done_o;
  logic [5:0]  iters_o;
  logic [7:0]  u_hat_o;
  logic [7:0]  x_hat_o;

  int n_tot = 0;
  int n_fail = 0;
  int cyc = 0;
  int ml [4][8];
  int mr [4][8];

  polar_bp_decoder u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .llr_i       (llr_i),
    .frozen_i    (frozen_i),
    .check_pass_i(check_pass_i),
    .busy_o      (busy_o),
    .chk_req_o   (chk_req_o),
    .done_o      (done_o),
    .iters_o     (iters_o),
    .u_hat_o     (u_hat_o),
    .x_hat_o     (x_hat_o)
  );

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_tot++;
      n_fail++;
      $display("FAIL R6 watchdog: actual %0d cycles expected fewer than 150000", cyc);
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tot++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bsat(int v);
    return (v > LIMV) ? LIMV : ((v < -LIMV) ? -LIMV : v);
  endfunction

  function automatic int bg(int a, int b);
    int aa;
    int ab;
    int m;
    aa = (a < 0) ? -a : a;
    ab = (b < 0) ? -b : b;
    m = (aa < ab) ? aa : ab;
    return ((a < 0) != (b < 0)) ? -m : m;
  endfunction

  function automatic void model_load(logic [63:0] llr, logic [7:0] frz);
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 8; i++) begin
        ml[s][i] = 0;
        mr[s][i] = 0;
      end
    end
    for (int i = 0; i < 8; i++) begin
      ml[3][i] = bsat(int'($signed(llr[i*8 +: 8])));
      mr[0][i] = frz[i] ? LIMV : 0;
    end
  endfunction

  function automatic void model_iter();
    for (int s = 0; s < 3; s++) begin
      for (int j = 0; j < 8; j++) begin
        if ((j & (1 << s)) == 0) begin
          int k;
          int a0;
          int a1;
          k = j + (1 << s);
          a0 = bsat(bg(mr[s][j], ml[s+1][k] + mr[s][k]));
          a1 = bsat(bg(mr[s][j], ml[s+1][j]) + mr[s][k]);
          mr[s+1][j] = a0;
          mr[s+1][k] = a1;
        end
      end
    end
    for (int s = 2; s >= 0; s--) begin
      for (int j = 0; j < 8; j++) begin
        if ((j & (1 << s)) == 0) begin
          int k;
          int b0;
          int b1;
          k = j + (1 << s);
          b0 = bsat(bg(ml[s+1][j], ml[s+1][k] + mr[s][k]));
          b1 = bsat(bg(mr[s][j], ml[s+1][j]) + ml[s+1][k]);
          ml[s][j] = b0;
          ml[s][k] = b1;
        end
      end
    end
  endfunction

  function automatic logic [7:0] model_hard(int s);
    logic [7:0] h;
    for (int i = 0; i < 8; i++) h[i] = (ml[s][i] + mr[s][i]) < 0;
    return h;
  endfunction

  task automatic run_frame(input logic [63:0] llr, input logic [7:0] frz,
                           input int pass_at, input bit poke, input bit hold);
    int cnt;
    int k;
    bit fin;
    logic [7:0] hu;
    logic [7:0] hx;
    logic [5:0] hi;
    model_load(llr, frz);
    @(negedge clk_i);
    llr_i = llr;
    frozen_i = frz;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
    cnt = 0;
    k = 0;
    fin = 0;
    while (!fin) begin
      while (!chk_req_o && cnt < 40) begin
        @(negedge clk_i);
        cnt++;
        if (poke && k == 1 && cnt == 2) begin
          start_i = 1'b1;
          llr_i = ~llr;
          frozen_i = ~frz;
        end else if (poke && k == 1 && cnt == 3) begin
          start_i = 1'b0;
          llr_i = llr;
          frozen_i = frz;
        end
      end
      k++;
      // R6
      chk(cnt == ((k == 1) ? 6 : 7), "R6", "cycles to check request", cnt, (k == 1) ? 6 : 7);
      if (!chk_req_o) begin
        fin = 1;
      end else begin
        model_iter();
        chk(u_hat_o == model_hard(0), "R3", "message decisions", u_hat_o, model_hard(0));
        chk(x_hat_o == model_hard(3), "R5", "codeword decisions", x_hat_o, model_hard(3));
        if (pass_at == k) check_pass_i = 1'b1;
        @(negedge clk_i);
        check_pass_i = 1'b0;
        cnt = 1;
        if (pass_at == k || k == CAPV) begin
          fin = 1;
          chk(done_o == 1'b1, (k == CAPV) ? "R8" : "R7", "done after stop", done_o, 1);
          chk(iters_o == 6'(k), (k == CAPV) ? "R8" : "R7", "iteration count", iters_o, k);
          chk(busy_o == 1'b0, "R7", "busy after done", busy_o, 0);
        end else begin
          chk(done_o == 1'b0, "R7", "done without pass", done_o, 0);
        end
      end
    end
    if (hold) begin
      hu = u_hat_o;
      hx = x_hat_o;
      hi = iters_o;
      llr_i = {$urandom(), $urandom()};
      frozen_i = 8'($urandom());
      check_pass_i = 1'b1;
      repeat (4) @(negedge clk_i);
      check_pass_i = 1'b0;
      // R10
      chk(u_hat_o == hu, "R10", "message decisions held", u_hat_o, hu);
      chk(x_hat_o == hx, "R10", "codeword decisions held", x_hat_o, hx);
      chk(iters_o == hi, "R10", "iteration count held", iters_o, hi);
      chk(done_o == 1'b1, "R10", "done held", done_o, 1);
    end
  endtask

  function automatic logic [63:0] rand_llr();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) begin
      int x;
      if ($urandom_range(0, 3) == 0) x = $urandom_range(0, 1) ? 127 : -128;
      else x = int'($urandom_range(0, 80)) - 40;
      v[i*8 +: 8] = 8'(x);
    end
    return v;
  endfunction

  function automatic logic [63:0] code_llr(logic [7:0] frz);
    logic [7:0] u;
    logic [7:0] x;
    logic [63:0] v;
    u = 8'($urandom()) & ~frz;
    x = u;
    for (int s = 0; s < 3; s++) begin
      for (int j = 0; j < 8; j++) begin
        if ((j & (1 << s)) == 0) x[j] = x[j] ^ x[j + (1 << s)];
      end
    end
    for (int i = 0; i < 8; i++) begin
      int m;
      m = int'($urandom_range(2, 30)) - 8;
      v[i*8 +: 8] = 8'(x[i] ? -m : m);
    end
    return v;
  endfunction

  initial begin
    void'($urandom(32'h5EED_0C0D));
    repeat (3) @(negedge clk_i);
    // R1
    chk(busy_o == 1'b0, "R1", "busy in reset", busy_o, 0);
    chk(done_o == 1'b0, "R1", "done in reset", done_o, 0);
    chk(chk_req_o == 1'b0, "R1", "check request in reset", chk_req_o, 0);
    chk(iters_o == 6'd0, "R1", "iterations in reset", iters_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1", "idle after reset", {busy_o, done_o}, 0);

    // R2: all frozen, zero channel
    run_frame(64'h0, 8'hFF, 2, 0, 0);
    // R4, R8: saturating -128 everywhere, never passes
    run_frame({8{8'h80}}, 8'h00, 0, 0, 1);
    // R4: alternating extremes
    run_frame({4{8'h80, 8'h7F}}, 8'h17, 3, 0, 1);
    // R7: pass on first iteration
    run_frame(code_llr(8'h17), 8'h17, 1, 0, 1);
    // R9: start pulse mid frame is ignored
    run_frame(rand_llr(), 8'h0B, 4, 1, 0);
    run_frame(rand_llr(), 8'h17, 0, 1, 1);

    for (int f = 0; f < 24; f++) begin
      logic [7:0] frz;
      frz = 8'($urandom());
      run_frame((f % 2 == 0) ? code_llr(frz) : rand_llr(), frz,
                $urandom_range(1, 8), (f % 5 == 0), (f % 3 == 0));
    end

    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

endmodule